// File: doc/BRIEF.md
# Two-Grain Private/Shared Ownership Directory

This block classifies every cache-line request from a set of cores as private or shared. It keeps one owner pointer per entry and has no sharer lists. Two small fully associative tables are searched in the same cycle. The page table records one owner core for a whole 64-line page, so a page used by a single core costs one entry. The line table holds single lines that have been split out of an owned page after another core touched them. A line entry carries either an owner pointer or a plain shared flag. On every request the line table's answer overrides the page table's answer.

When a core touches a line whose recorded owner is a different core, the block sends a recovery notification to that owner and waits for its answer. An acknowledge makes the line shared. A negative acknowledge hands the line, still private, to the requester. When a table is full, a free slot is used first, then a shared entry, which is overwritten with no message. Only if neither exists is a private entry evicted, and that costs a downgrade notification to its owner. The request stalls until the owner responds. A page victim's owner is told to treat every line of that page as shared.

The block takes one request at a time. It raises `busy` while a notification is outstanding and reports each result as a one-cycle `done_valid` pulse.

Top module: `dgd_directory`

## Requirements
- R1: Line and page tables are searched together. When a line entry exists, its result is used whatever the page entry says.
- R2: A request that misses both tables, with a free page slot, allocates a page entry owned by the requester. The result is private, with no notification, one cycle after acceptance.
- R3: A request by the owner of a page, with no line entry present, returns private, sends no notification and changes no state.
- R4: A request by another core to an owned page allocates a line entry. It sends a recovery notification (`note_kind` 0) to the page owner, with the requested line address.
- R5: A recovery answered with `resp_ack`=1 returns shared. Later requests by any core to that line return shared with no notification.
- R6: A recovery answered with `resp_ack`=0 returns private and records the requester as line owner. A later request by another core sends the recovery notification to that new owner.
- R7: When the line table is full, the lowest-index shared entry is replaced with no notification. Afterwards that line no longer resolves as shared.
- R8: When the line table is full of private entries, a round-robin victim (starting at slot 0 after reset) is evicted first. The block sends a line downgrade notification (`note_kind` 1) to the victim's owner with its line address. It allocates only after the response, and then runs the recovery.
- R9: When both tables miss and the page table is full, a round-robin page victim is evicted. The block sends a page downgrade notification (`note_kind` 2) to its owner, with the page's first line address. The result is private once the owner responds.
- R10: `busy` is high exactly while a notification is pending. Requests presented while busy are ignored. Notification fields hold steady until `resp_valid`.
- R11: After reset `busy`, `done_valid` and `note_valid` are low, and both tables are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present (taken only when not busy) |
| req_core | input | $clog2(CORES) | Requesting core |
| req_addr | input | LINE_AW | Line address of the request |
| busy | output | 1 | A notification is outstanding |
| done_valid | output | 1 | One-cycle result strobe |
| done_shared | output | 1 | Result: 1 shared, 0 private |
| note_valid | output | 1 | Notification to a core is pending |
| note_kind | output | 2 | 0 recovery, 1 line downgrade, 2 page downgrade |
| note_core | output | $clog2(CORES) | Core that must answer |
| note_addr | output | LINE_AW | Line address, or first line of the page |
| resp_valid | input | 1 | Answer from the notified core |
| resp_ack | input | 1 | Recovery answer: 1 share, 0 give up |

## Verification
The hardest state to reach from the ports is a full line table that holds only private entries. Only in that state does a request produce two notifications in a row: the downgrade of the victim, then the recovery. Getting there means first filling the table with a mix of shared and private lines. Then each shared entry has to be displaced by a later split-off with a negative answer, until none is left. The vector walk does this in order and tracks the slot contents by hand. A second round-robin page eviction, together with a request presented while busy, then shows that the ignored request left no page entry behind.

// File: rtl/dgd_pkg.sv
package dgd_pkg;
  typedef enum logic [1:0] {
    NK_RECOVER   = 2'd0,
    NK_LINE_DOWN = 2'd1,
    NK_PAGE_DOWN = 2'd2
  } note_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVICT_LINE,
    ST_EVICT_PAGE,
    ST_RECOVER
  } dir_state_e;
endpackage

// File: rtl/dgd_table.sv
module dgd_table #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 16,
  parameter int OWN_W   = 2,
  parameter int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output logic [IW-1:0]    hit_idx,
  output logic [OWN_W-1:0] hit_owner,
  output logic             hit_shared,
  output logic [IW-1:0]    vic_idx,
  output logic             vic_free,
  output logic             vic_shared,
  output logic [OWN_W-1:0] vic_owner,
  output logic [TAG_W-1:0] vic_tag,
  input  logic             adv_rr,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [OWN_W-1:0] wr_owner,
  input  logic             wr_shared
);
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [ENTRIES-1:0] shr_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [OWN_W-1:0]   own_q [ENTRIES];
  logic [IW-1:0]      rr_q, rr_d;
  logic [ENTRIES-1:0] hit_vec;
  logic [IW-1:0]      free_idx, shr_idx;
  logic               any_free, any_shr;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid_q[g] && (tag_q[g] == lk_tag);
  end

  always_comb begin
    hit = 1'b0; hit_idx = '0;
    any_free = 1'b0; free_idx = '0;
    any_shr = 1'b0; shr_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        hit = 1'b1;
        hit_idx = IW'(i);
      end
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        any_free = 1'b1;
        free_idx = IW'(i);
      end
      if (valid_q[i] && shr_q[i]) begin
        any_shr = 1'b1;
        shr_idx = IW'(i);
      end
    end
  end

  assign hit_owner  = own_q[hit_idx];
  assign hit_shared = shr_q[hit_idx];
  assign vic_free   = any_free;
  assign vic_shared = !any_free && any_shr;
  assign vic_idx    = any_free ? free_idx : (any_shr ? shr_idx : rr_q);
  assign vic_owner  = own_q[vic_idx];
  assign vic_tag    = tag_q[vic_idx];

  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d[wr_idx] = 1'b1;
    rr_d = rr_q;
    if (adv_rr) rr_d = (rr_q == IW'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      valid_q <= valid_d;
      rr_q    <= rr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      own_q[wr_idx] <= wr_owner;
      shr_q[wr_idx] <= wr_shared;
    end
  end

  // R1: a tag is never held twice, so at most one entry matches
  a_r1_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R8: the round-robin pointer stays inside the table
  a_r8_rr_range: assert property (@(posedge clk) disable iff (!rst_n)
    rr_q <= IW'(ENTRIES - 1));
endmodule

// File: rtl/dgd_directory.sv
module dgd_directory
  import dgd_pkg::*;
#(
  parameter int CORES        = 4,
  parameter int LINE_AW      = 16,
  parameter int PAGE_LINES   = 64,
  parameter int LINE_ENTRIES = 8,
  parameter int PAGE_ENTRIES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [$clog2(CORES)-1:0]   req_core,
  input  logic [LINE_AW-1:0]         req_addr,
  output logic                       busy,
  output logic                       done_valid,
  output logic                       done_shared,
  output logic                       note_valid,
  output logic [1:0]                 note_kind,
  output logic [$clog2(CORES)-1:0]   note_core,
  output logic [LINE_AW-1:0]         note_addr,
  input  logic                       resp_valid,
  input  logic                       resp_ack
);
  localparam int CW     = $clog2(CORES);
  localparam int POFF   = $clog2(PAGE_LINES);
  localparam int PTAG_W = LINE_AW - POFF;
  localparam int LIW    = (LINE_ENTRIES > 1) ? $clog2(LINE_ENTRIES) : 1;
  localparam int PIW    = (PAGE_ENTRIES > 1) ? $clog2(PAGE_ENTRIES) : 1;

  dir_state_e          state_q, state_d;
  logic [CW-1:0]       core_q, core_d, pown_q, pown_d;
  logic [LINE_AW-1:0]  addr_q, addr_d;
  logic [LIW-1:0]      lidx_q, lidx_d;
  logic [PIW-1:0]      pidx_q, pidx_d;
  logic                nv_q, nv_d, dv_q, dv_d, ds_q, ds_d;
  note_kind_e          nk_q, nk_d;
  logic [CW-1:0]       nc_q, nc_d;
  logic [LINE_AW-1:0]  na_q, na_d;

  logic                l_hit, l_hshr, l_vfree, l_vshr, l_wr, l_wshr, l_adv;
  logic [LIW-1:0]      l_hidx, l_vidx, l_widx;
  logic [CW-1:0]       l_hown, l_vown, l_wown;
  logic [LINE_AW-1:0]  l_vtag, l_wtag;
  logic                p_hit, p_hshr, p_vfree, p_vshr, p_wr, p_adv;
  logic [PIW-1:0]      p_hidx, p_vidx, p_widx;
  logic [CW-1:0]       p_hown, p_vown, p_wown;
  logic [PTAG_W-1:0]   p_vtag, p_wtag;

  dgd_table #(.ENTRIES(LINE_ENTRIES), .TAG_W(LINE_AW), .OWN_W(CW)) line_tbl_i (
    .clk, .rst_n, .lk_tag(req_addr),
    .hit(l_hit), .hit_idx(l_hidx), .hit_owner(l_hown), .hit_shared(l_hshr),
    .vic_idx(l_vidx), .vic_free(l_vfree), .vic_shared(l_vshr),
    .vic_owner(l_vown), .vic_tag(l_vtag), .adv_rr(l_adv),
    .wr_en(l_wr), .wr_idx(l_widx), .wr_tag(l_wtag), .wr_owner(l_wown),
    .wr_shared(l_wshr));

  dgd_table #(.ENTRIES(PAGE_ENTRIES), .TAG_W(PTAG_W), .OWN_W(CW)) page_tbl_i (
    .clk, .rst_n, .lk_tag(req_addr[LINE_AW-1:POFF]),
    .hit(p_hit), .hit_idx(p_hidx), .hit_owner(p_hown), .hit_shared(p_hshr),
    .vic_idx(p_vidx), .vic_free(p_vfree), .vic_shared(p_vshr),
    .vic_owner(p_vown), .vic_tag(p_vtag), .adv_rr(p_adv),
    .wr_en(p_wr), .wr_idx(p_widx), .wr_tag(p_wtag), .wr_owner(p_wown),
    .wr_shared(1'b0));

  always_comb begin
    state_d = state_q; core_d = core_q; addr_d = addr_q; pown_d = pown_q;
    lidx_d = lidx_q; pidx_d = pidx_q;
    nv_d = nv_q; nk_d = nk_q; nc_d = nc_q; na_d = na_q;
    dv_d = 1'b0; ds_d = 1'b0;
    l_wr = 1'b0; l_widx = l_vidx; l_wtag = req_addr; l_wown = p_hown; l_wshr = 1'b0;
    l_adv = 1'b0;
    p_wr = 1'b0; p_widx = p_vidx; p_wtag = req_addr[LINE_AW-1:POFF]; p_wown = req_core;
    p_adv = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        core_d = req_core;
        addr_d = req_addr;
        if (l_hit) begin
          lidx_d = l_hidx;
          if (l_hshr || l_hown == req_core) begin
            dv_d = 1'b1; ds_d = l_hshr;
          end else begin
            nv_d = 1'b1; nk_d = NK_RECOVER; nc_d = l_hown; na_d = req_addr;
            state_d = ST_RECOVER;
          end
        end else if (p_hit && !p_hshr) begin
          pidx_d = p_hidx;
          pown_d = p_hown;
          if (p_hown == req_core) begin
            dv_d = 1'b1;
          end else if (l_vfree || l_vshr) begin
            l_wr = 1'b1; lidx_d = l_vidx;
            nv_d = 1'b1; nk_d = NK_RECOVER; nc_d = p_hown; na_d = req_addr;
            state_d = ST_RECOVER;
          end else begin
            l_adv = 1'b1; lidx_d = l_vidx;
            nv_d = 1'b1; nk_d = NK_LINE_DOWN; nc_d = l_vown; na_d = l_vtag;
            state_d = ST_EVICT_LINE;
          end
        end else if (p_vfree || p_vshr) begin
          p_wr = 1'b1; dv_d = 1'b1;
        end else begin
          p_adv = 1'b1; pidx_d = p_vidx;
          nv_d = 1'b1; nk_d = NK_PAGE_DOWN; nc_d = p_vown;
          na_d = {p_vtag, {POFF{1'b0}}};
          state_d = ST_EVICT_PAGE;
        end
      end
      ST_EVICT_LINE: if (resp_valid) begin
        l_wr = 1'b1; l_widx = lidx_q; l_wtag = addr_q; l_wown = pown_q;
        nk_d = NK_RECOVER; nc_d = pown_q; na_d = addr_q;
        state_d = ST_RECOVER;
      end
      ST_EVICT_PAGE: if (resp_valid) begin
        p_wr = 1'b1; p_widx = pidx_q; p_wtag = addr_q[LINE_AW-1:POFF]; p_wown = core_q;
        nv_d = 1'b0; dv_d = 1'b1;
        state_d = ST_IDLE;
      end
      ST_RECOVER: if (resp_valid) begin
        l_wr = 1'b1; l_widx = lidx_q; l_wtag = addr_q; l_wown = core_q; l_wshr = resp_ack;
        nv_d = 1'b0; dv_d = 1'b1; ds_d = resp_ack;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      nv_q    <= 1'b0;
      dv_q    <= 1'b0;
      ds_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      nv_q    <= nv_d;
      dv_q    <= dv_d;
      ds_q    <= ds_d;
    end
  end

  always_ff @(posedge clk) begin
    core_q <= core_d; addr_q <= addr_d; pown_q <= pown_d;
    lidx_q <= lidx_d; pidx_q <= pidx_d;
    nk_q <= nk_d; nc_q <= nc_d; na_q <= na_d;
  end

  assign busy        = (state_q != ST_IDLE);
  assign done_valid  = dv_q;
  assign done_shared = ds_q;
  assign note_valid  = nv_q;
  assign note_kind   = nk_q;
  assign note_core   = nc_q;
  assign note_addr   = na_q;

  // R10: a pending notification always stalls the request side
  a_r10_note_busy: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid |-> busy);
  // R10: a result is only reported once the block is free again
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !busy);
  // R10: notification fields hold until answered
  a_r10_note_hold: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid && !resp_valid |=> note_valid && $stable(note_kind)
      && $stable(note_core) && $stable(note_addr));
  // R5: an acknowledged recovery yields shared
  a_r5_ack_shared: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid && note_kind == NK_RECOVER && resp_valid && resp_ack
      |=> done_valid && done_shared);
  // R6: a refused recovery yields private
  a_r6_nack_private: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid && note_kind == NK_RECOVER && resp_valid && !resp_ack
      |=> done_valid && !done_shared);
  // R8: a line downgrade is always followed by a recovery
  a_r8_then_recover: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid && note_kind == NK_LINE_DOWN && resp_valid
      |=> note_valid && note_kind == NK_RECOVER);
  // R9: a page downgrade ends in a private result
  a_r9_page_private: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid && note_kind == NK_PAGE_DOWN && resp_valid
      |=> done_valid && !done_shared);
endmodule

// File: tb/dgd_directory_tb_top.sv
`timescale 1ns/1ps
module dgd_directory_tb_top;
  logic        clk, rst_n, req_valid, resp_valid, resp_ack;
  logic [1:0]  req_core, note_kind, note_core;
  logic [15:0] req_addr, note_addr;
  logic        busy, done_valid, done_shared, note_valid;
  int          n_chk = 0, n_err = 0;
  bit          ended = 0;

  dgd_directory #(.CORES(4), .LINE_AW(16), .PAGE_LINES(64),
                  .LINE_ENTRIES(4), .PAGE_ENTRIES(2)) dut_i (
    .clk, .rst_n, .req_valid, .req_core, .req_addr, .busy, .done_valid,
    .done_shared, .note_valid, .note_kind, .note_core, .note_addr,
    .resp_valid, .resp_ack);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [1:0]  core; logic [15:0] addr; logic [1:0] n;
    logic [1:0]  k0; logic [1:0] c0; logic [15:0] a0;
    logic [1:0]  k1; logic [1:0] c1; logic [15:0] a1;
    logic        ack; logic shr;
  } vec_t;

  localparam vec_t VEC [19] = '{
    '{0, 16'h0040, 0, 0, 0, 16'h0,    0, 0, 16'h0,    0, 0}, // R2 new page
    '{0, 16'h0041, 0, 0, 0, 16'h0,    0, 0, 16'h0,    0, 0}, // R3 owner again
    '{1, 16'h0042, 1, 0, 0, 16'h0042, 0, 0, 16'h0,    1, 1}, // R4 R5 ack
    '{2, 16'h0042, 0, 0, 0, 16'h0,    0, 0, 16'h0,    0, 1}, // R5 shared hit
    '{0, 16'h0042, 0, 0, 0, 16'h0,    0, 0, 16'h0,    0, 1}, // R1 line wins
    '{1, 16'h0043, 1, 0, 0, 16'h0043, 0, 0, 16'h0,    0, 0}, // R6 nack
    '{1, 16'h0043, 0, 0, 0, 16'h0,    0, 0, 16'h0,    0, 0}, // R6 new owner
    '{0, 16'h0043, 1, 0, 1, 16'h0043, 0, 0, 16'h0,    0, 0}, // R1 R6
    '{3, 16'h0080, 0, 0, 0, 16'h0,    0, 0, 16'h0,    0, 0}, // R2 second page
    '{3, 16'h0044, 1, 0, 0, 16'h0044, 0, 0, 16'h0,    1, 1}, // R4
    '{2, 16'h0045, 1, 0, 0, 16'h0045, 0, 0, 16'h0,    0, 0}, // R4 table full
    '{1, 16'h0046, 1, 0, 0, 16'h0046, 0, 0, 16'h0,    1, 1}, // R7 silent drop
    '{2, 16'h0042, 1, 0, 0, 16'h0042, 0, 0, 16'h0,    0, 0}, // R7 dropped line
    '{1, 16'h0047, 1, 0, 0, 16'h0047, 0, 0, 16'h0,    0, 0}, // R7 last shared
    '{3, 16'h0048, 2, 1, 2, 16'h0042, 0, 0, 16'h0048, 1, 1}, // R8
    '{1, 16'h00C0, 1, 2, 0, 16'h0040, 0, 0, 16'h0,    1, 0}, // R9
    '{2, 16'h0041, 1, 2, 3, 16'h0080, 0, 0, 16'h0,    1, 0}, // R9 rr
    '{1, 16'h00C1, 0, 0, 0, 16'h0,    0, 0, 16'h0,    0, 0}, // R3
    '{0, 16'h0043, 0, 0, 0, 16'h0,    0, 0, 16'h0,    0, 0}  // R1
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_access(input logic [1:0] core, input logic [15:0] addr,
                           input bit ack_last, input int nexp,
                           output bit got, output bit shr, output int n,
                           output logic [1:0] k [2], output logic [1:0] c [2],
                           output logic [15:0] a [2]);
    got = 0; shr = 0; n = 0;
    k = '{2'd3, 2'd3}; c = '{2'd0, 2'd0}; a = '{16'h0, 16'h0};
    @(negedge clk);
    req_valid = 1'b1; req_core = core; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (done_valid) begin
        got = 1; shr = done_shared;
        break;
      end
      if (note_valid) begin
        if (n < 2) begin
          k[n] = note_kind; c[n] = note_core; a[n] = note_addr;
        end
        n++;
        resp_valid = 1'b1;
        resp_ack = (n >= nexp) ? ack_last : 1'b1;
      end
      @(negedge clk);
      resp_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    bit got, shr;
    int n;
    logic [1:0]  k [2];
    logic [1:0]  c [2];
    logic [15:0] a [2];
    string tag;
    rst_n = 1'b0; req_valid = 1'b0; req_core = '0; req_addr = '0;
    resp_valid = 1'b0; resp_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: idle outputs after reset
    chk(!busy, "R11", "busy", busy, 0);
    chk(!done_valid, "R11", "done_valid", done_valid, 0);
    chk(!note_valid, "R11", "note_valid", note_valid, 0);

    foreach (VEC[v]) begin
      tag = $sformatf("vector%0d", v);
      do_access(VEC[v].core, VEC[v].addr, VEC[v].ack, int'(VEC[v].n),
                got, shr, n, k, c, a);
      chk(got, tag, "done seen", got, 1);
      chk(n == int'(VEC[v].n), tag, "notes", n, VEC[v].n);
      chk(shr == VEC[v].shr, tag, "shared", shr, VEC[v].shr);
      if (VEC[v].n >= 1) begin
        chk(k[0] == VEC[v].k0, tag, "kind0", k[0], VEC[v].k0);
        chk(c[0] == VEC[v].c0, tag, "core0", c[0], VEC[v].c0);
        chk(a[0] == VEC[v].a0, tag, "addr0", a[0], VEC[v].a0);
      end
      if (VEC[v].n == 2) begin
        chk(k[1] == VEC[v].k1, tag, "kind1", k[1], VEC[v].k1);
        chk(c[1] == VEC[v].c1, tag, "core1", c[1], VEC[v].c1);
        chk(a[1] == VEC[v].a1, tag, "addr1", a[1], VEC[v].a1);
      end
    end

    // R10: request while busy is ignored; notification held
    @(negedge clk);
    req_valid = 1'b1; req_core = 2'd0; req_addr = 16'h00C5;
    @(negedge clk);
    req_valid = 1'b0;
    chk(note_valid && busy, "R10", "busy with note", {note_valid, busy}, 3);
    chk(note_kind == 2'd0 && note_core == 2'd1, "R4", "recover target",
        {note_kind, note_core}, 1);
    req_valid = 1'b1; req_core = 2'd3; req_addr = 16'h0200;
    repeat (2) @(negedge clk);
    chk(note_valid && note_addr == 16'h00C5 && !done_valid, "R10", "note held",
        note_addr, 16'h00C5);
    req_valid = 1'b0; resp_valid = 1'b1; resp_ack = 1'b0;
    @(negedge clk);
    resp_valid = 1'b0;
    chk(done_valid && !done_shared, "R6", "nack result", {done_valid, done_shared}, 2);
    repeat (3) begin
      @(negedge clk);
      chk(!done_valid && !note_valid && !busy, "R10", "quiet after",
          {done_valid, note_valid, busy}, 0);
    end
    // R10 R9: the ignored request allocated nothing; page victim is page 3
    do_access(2'd0, 16'h0200, 1'b1, 1, got, shr, n, k, c, a);
    chk(n == 1 && k[0] == 2'd2, "R9", "page eviction kind", k[0], 2);
    chk(c[0] == 2'd1 && a[0] == 16'h00C0, "R9", "page victim", a[0], 16'h00C0);
    chk(got && !shr, "R9", "private after evict", shr, 0);

    ended = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule